// File: doc/BRIEF.md
# Addressed Framed-Packet Receiver

This block sits behind a UART receiver on a shared multi-drop bus. It takes a stream of received bytes, one per cycle with a valid flag, and decodes the consistent-overhead byte stuffing used on the bus. A zero byte marks the end of every packet. The decoded bytes go into a 64-byte staging buffer and their number is counted. At each delimiter the packet is classified by its decoded length and, for single-byte packets, by its content.

A small protocol state machine controls what the node accepts. A 4-byte packet carrying this node's address arms the node. The next two 64-byte packets then become the two halves of a frame of 32 little-endian 16-bit words each. When the second half arrives, the node signals that the frame is complete. A single zero byte is a discovery request, and the node answers it only during a boot window measured in millisecond ticks. Any other single byte is a command. Every packet the node does not expect is counted and drops the node back to the idle ignore state.

The stored frame is read through a combinational word port. Turning a discovery request into reply bytes on the wire is left to logic outside this block.

Top module: `fpkt_receiver`

## Requirements
- R1: Bytes that arrive before the first zero byte after reset are discarded. An empty packet (a zero byte that directly follows a zero byte) is discarded too. Neither has any visible effect.
- R2: Decoding works as follows. A code byte n (1 to 255) is followed by n-1 literal bytes. When another code byte follows and n is not 255, a zero data byte is inserted. The zero byte that ends the packet is not part of the data.
- R3: A packet of one decoded byte equal to 0x00 is a discovery request, provided that fewer than BOOT_WINDOW_MS pulses of `msTick` have arrived since reset. In that case `discReq` is high for one cycle. In that same cycle `replyData` is `{devType, devAddr}`, with the address in bits 31:0.
- R4: A discovery request that arrives after BOOT_WINDOW_MS ticks produces no output.
- R5: A packet of one decoded nonzero byte pulses `cmdStrobe` for one cycle, with that byte on `cmdByte`. The protocol state then returns to ignore, in any state.
- R6: A 4-byte packet, read little-endian (first byte is bits 7:0), is compared with `devAddr`. On a match the state becomes addressed. On a mismatch it becomes ignore.
- R7: A 64-byte packet received in the addressed state is stored as half 0. The state then becomes awaiting the second half.
- R8: A 64-byte packet received while awaiting the second half is stored as half 1. `frameReady` is then high for one cycle, and the state returns to ignore.
- R9: Any other case increments `invalidCount` and forces the ignore state. This covers any other decoded length, including 0, and a 64-byte packet in the ignore state.
- R10: A packet that decodes to more than 64 bytes is treated as invalid under R9. It never changes the stored frame.
- R11: After reset the state is ignore, `invalidCount` is 0, every frame word is 0 and all strobes are low.
- R12: `fbRdAddr[5]` selects the half and `fbRdAddr[4:0]` selects the word. Word k of a half is byte 2k in bits 7:0 and byte 2k+1 in bits 15:8 of the stored packet. It is visible combinationally on `fbRdData`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| byteValid | input | 1 | `byteData` holds a received byte this cycle |
| byteData | input | 8 | Received bus byte |
| msTick | input | 1 | One-cycle pulse per millisecond |
| devAddr | input | 32 | This node's bus address |
| devType | input | 16 | This node's type code |
| fbRdAddr | input | 6 | Frame read address: half and word |
| fbRdData | output | 16 | Frame word at `fbRdAddr` |
| discReq | output | 1 | Discovery reply request pulse |
| replyData | output | 48 | Reply payload `{devType, devAddr}` |
| cmdStrobe | output | 1 | Command received pulse |
| cmdByte | output | 8 | Command byte |
| frameReady | output | 1 | Both frame halves stored pulse |
| invalidCount | output | 16 | Count of rejected packets |

## Verification
The bench sends packets that contain zero bytes. A design that mishandles the inserted zeros stores shifted words, and the word readback after a complete frame catches this. It sends a code byte followed directly by a delimiter, which is a zero-length packet. A design that treats this like an empty packet would leave the invalid count unchanged. It sends a packet that overruns the 64-byte buffer. A design that wraps the write index would corrupt the stored half, and one that counts the overrun packet as a valid 64-byte packet would advance the state. A command placed between the address and the data, and a discovery request sent after the boot window, check that the state returns to ignore and that the boot-window gate works.

// File: rtl/fpkt_pkg.sv
package fpkt_pkg;
  typedef enum logic [1:0] {PS_IGNORE, PS_ADDRESSED, PS_EXPECT2} protoState_t;
  typedef enum logic [1:0] {CS_SYNC, CS_START, CS_DATA, CS_CODE} cobsState_t;

  typedef struct packed {
    logic wrEn;
    logic wrZero;
    logic clrLen;
    logic cpyHalf0;
    logic cpyHalf1;
  } dpCtl_t;
endpackage

// File: rtl/fpkt_dpath.sv
module fpkt_dpath
  import fpkt_pkg::*;
#(
  parameter int WORDS  = 32,
  parameter int WORD_W = 16,
  parameter int ADDR_W = 32,
  localparam int BPW        = WORD_W / 8,
  localparam int CAP_BYTES  = WORDS * BPW,
  localparam int LEN_W      = $clog2(CAP_BYTES + 1),
  localparam int IDX_W      = $clog2(CAP_BYTES),
  localparam int ADDR_BYTES = ADDR_W / 8,
  localparam int FB_AW      = $clog2(2 * WORDS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [7:0]        byteData,
  input  dpCtl_t            ctl,
  input  logic [ADDR_W-1:0] devAddr,
  input  logic [FB_AW-1:0]  rdAddr,
  output logic [WORD_W-1:0] rdData,
  output logic [LEN_W-1:0]  rxLen,
  output logic              rxOvf,
  output logic              addrMatch,
  output logic [7:0]        firstByte
);
  logic [7:0]        stage [CAP_BYTES];
  logic [WORD_W-1:0] fbMem [2][WORDS];
  logic [ADDR_W-1:0] addrRx;

  // staging buffer and length counter
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxLen <= '0;
      rxOvf <= 1'b0;
      for (int i = 0; i < CAP_BYTES; i++) stage[i] <= '0;
    end else if (ctl.clrLen) begin
      rxLen <= '0;
      rxOvf <= 1'b0;
    end else if (ctl.wrEn) begin
      if (rxLen == LEN_W'(CAP_BYTES)) begin
        rxOvf <= 1'b1;
      end else begin
        stage[rxLen[IDX_W-1:0]] <= ctl.wrZero ? 8'h00 : byteData;
        rxLen <= rxLen + 1'b1;
      end
    end
  end

  // frame store, two halves
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int h = 0; h < 2; h++)
        for (int w = 0; w < WORDS; w++) fbMem[h][w] <= '0;
    end else begin
      for (int w = 0; w < WORDS; w++)
        for (int b = 0; b < BPW; b++) begin
          if (ctl.cpyHalf0) fbMem[0][w][b*8 +: 8] <= stage[w*BPW + b];
          if (ctl.cpyHalf1) fbMem[1][w][b*8 +: 8] <= stage[w*BPW + b];
        end
    end
  end

  for (genvar g = 0; g < ADDR_BYTES; g++) begin : g_addr
    assign addrRx[g*8 +: 8] = stage[g];
  end

  assign addrMatch = (addrRx == devAddr);
  assign firstByte = stage[0];
  assign rdData    = fbMem[rdAddr[FB_AW-1]][rdAddr[FB_AW-2:0]];

  // R10
  len_cap_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxLen <= LEN_W'(CAP_BYTES));

  // R10
  ovf_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rxOvf && !ctl.clrLen) |=> (rxOvf && rxLen == LEN_W'(CAP_BYTES)));
endmodule

// File: rtl/fpkt_ctrl.sv
module fpkt_ctrl
  import fpkt_pkg::*;
#(
  parameter int ADDR_W         = 32,
  parameter int TYPE_W         = 16,
  parameter int INV_W          = 16,
  parameter int BOOT_WINDOW_MS = 100,
  parameter int CAP_BYTES      = 64,
  localparam int LEN_W         = $clog2(CAP_BYTES + 1),
  localparam int ADDR_BYTES    = ADDR_W / 8,
  localparam int BOOT_W        = $clog2(BOOT_WINDOW_MS + 1)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     byteValid,
  input  logic [7:0]               byteData,
  input  logic                     msTick,
  input  logic [ADDR_W-1:0]        devAddr,
  input  logic [TYPE_W-1:0]        devType,
  input  logic [LEN_W-1:0]         rxLen,
  input  logic                     rxOvf,
  input  logic                     addrMatch,
  input  logic [7:0]               firstByte,
  output dpCtl_t                   ctl,
  output logic                     discReq,
  output logic [ADDR_W+TYPE_W-1:0] replyData,
  output logic                     cmdStrobe,
  output logic [7:0]               cmdByte,
  output logic                     frameReady,
  output logic [INV_W-1:0]         invalidCount
);
  cobsState_t  cs, csNext;
  protoState_t ps, psNext;
  logic [7:0]  cnt, cntNext;
  logic        full, fullNext;
  logic [BOOT_W-1:0] bootCnt;
  logic dispatch, discHit, cmdHit, frameHit, bad;

  wire isDelim = byteValid && (byteData == 8'h00);
  wire isData  = byteValid && (byteData != 8'h00);
  wire bootOpen = (bootCnt < BOOT_W'(BOOT_WINDOW_MS));

  // byte-stuffing decoder
  always_comb begin
    csNext   = cs;
    cntNext  = cnt;
    fullNext = full;
    ctl      = '0;
    dispatch = 1'b0;
    if (isDelim) begin
      csNext     = (cs == CS_SYNC) ? CS_START : CS_START;
      ctl.clrLen = 1'b1;
      dispatch   = (cs == CS_DATA) || (cs == CS_CODE);
    end else if (isData) begin
      case (cs)
        CS_START, CS_CODE: begin
          if (cs == CS_CODE && !full) begin
            ctl.wrEn   = 1'b1;
            ctl.wrZero = 1'b1;
          end
          cntNext  = byteData - 8'd1;
          fullNext = (byteData == 8'hFF);
          csNext   = (byteData == 8'h01) ? CS_CODE : CS_DATA;
        end
        CS_DATA: begin
          ctl.wrEn = 1'b1;
          cntNext  = cnt - 8'd1;
          if (cnt == 8'd1) csNext = CS_CODE;
        end
        default: ;
      endcase
    end
  end

  // packet classification and protocol state
  always_comb begin
    psNext   = ps;
    discHit  = 1'b0;
    cmdHit   = 1'b0;
    frameHit = 1'b0;
    bad      = 1'b0;
    ctl.cpyHalf0 = 1'b0;
    ctl.cpyHalf1 = 1'b0;
    if (dispatch) begin
      if (rxOvf) begin
        bad = 1'b1;
      end else if (rxLen == LEN_W'(1)) begin
        if (firstByte == 8'h00) discHit = bootOpen;
        else begin
          cmdHit = 1'b1;
          psNext = PS_IGNORE;
        end
      end else if (rxLen == LEN_W'(ADDR_BYTES)) begin
        psNext = addrMatch ? PS_ADDRESSED : PS_IGNORE;
      end else if (rxLen == LEN_W'(CAP_BYTES) && ps == PS_ADDRESSED) begin
        ctl.cpyHalf0 = 1'b1;
        psNext = PS_EXPECT2;
      end else if (rxLen == LEN_W'(CAP_BYTES) && ps == PS_EXPECT2) begin
        ctl.cpyHalf1 = 1'b1;
        frameHit = 1'b1;
        psNext = PS_IGNORE;
      end else begin
        bad = 1'b1;
      end
      if (bad) psNext = PS_IGNORE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cs           <= CS_SYNC;
      ps           <= PS_IGNORE;
      cnt          <= '0;
      full         <= 1'b0;
      bootCnt      <= '0;
      discReq      <= 1'b0;
      cmdStrobe    <= 1'b0;
      frameReady   <= 1'b0;
      cmdByte      <= '0;
      replyData    <= '0;
      invalidCount <= '0;
    end else begin
      cs         <= csNext;
      ps         <= psNext;
      cnt        <= cntNext;
      full       <= fullNext;
      discReq    <= discHit;
      cmdStrobe  <= cmdHit;
      frameReady <= frameHit;
      if (msTick && bootOpen) bootCnt <= bootCnt + 1'b1;
      if (cmdHit) cmdByte <= firstByte;
      if (discHit) replyData <= {devType, devAddr};
      if (bad) invalidCount <= invalidCount + 1'b1;
    end
  end

  // R1
  sync_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cs == CS_SYNC) |-> (invalidCount == '0 && ps == PS_IGNORE));

  // R4
  disc_window_chk: assert property (@(posedge clk) disable iff (!rstN)
    discReq |-> ($past(bootCnt) < BOOT_W'(BOOT_WINDOW_MS)));

  // R5
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({discReq, cmdStrobe, frameReady}));

  // R8
  half2_state_chk: assert property (@(posedge clk) disable iff (!rstN)
    frameReady |-> ($past(ps) == PS_EXPECT2 && ps == PS_IGNORE));

  // R9
  invalid_ignore_chk: assert property (@(posedge clk) disable iff (!rstN)
    (invalidCount != $past(invalidCount)) |-> (ps == PS_IGNORE));
endmodule

// File: rtl/fpkt_receiver.sv
module fpkt_receiver
  import fpkt_pkg::*;
#(
  parameter int WORDS          = 32,
  parameter int WORD_W         = 16,
  parameter int ADDR_W         = 32,
  parameter int TYPE_W         = 16,
  parameter int INV_W          = 16,
  parameter int BOOT_WINDOW_MS = 100,
  localparam int CAP_BYTES     = WORDS * WORD_W / 8,
  localparam int LEN_W         = $clog2(CAP_BYTES + 1),
  localparam int FB_AW         = $clog2(2 * WORDS)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     byteValid,
  input  logic [7:0]               byteData,
  input  logic                     msTick,
  input  logic [ADDR_W-1:0]        devAddr,
  input  logic [TYPE_W-1:0]        devType,
  input  logic [FB_AW-1:0]         fbRdAddr,
  output logic [WORD_W-1:0]        fbRdData,
  output logic                     discReq,
  output logic [ADDR_W+TYPE_W-1:0] replyData,
  output logic                     cmdStrobe,
  output logic [7:0]               cmdByte,
  output logic                     frameReady,
  output logic [INV_W-1:0]         invalidCount
);
  dpCtl_t           ctl;
  logic [LEN_W-1:0] rxLen;
  logic             rxOvf, addrMatch;
  logic [7:0]       firstByte;

  fpkt_ctrl #(
    .ADDR_W(ADDR_W), .TYPE_W(TYPE_W), .INV_W(INV_W),
    .BOOT_WINDOW_MS(BOOT_WINDOW_MS), .CAP_BYTES(CAP_BYTES)
  ) u_ctrl (
    .clk, .rstN, .byteValid, .byteData, .msTick, .devAddr, .devType,
    .rxLen, .rxOvf, .addrMatch, .firstByte, .ctl,
    .discReq, .replyData, .cmdStrobe, .cmdByte, .frameReady, .invalidCount
  );

  fpkt_dpath #(
    .WORDS(WORDS), .WORD_W(WORD_W), .ADDR_W(ADDR_W)
  ) u_dpath (
    .clk, .rstN, .byteData, .ctl, .devAddr,
    .rdAddr(fbRdAddr), .rdData(fbRdData),
    .rxLen, .rxOvf, .addrMatch, .firstByte
  );
endmodule

// File: tb/fpkt_receiver_tb.sv
module fpkt_receiver_tb;
  typedef logic [7:0] bq_t[$];
  typedef struct {
    int          kind;   // 1 discovery, 2 command, 3 frame
    logic [47:0] val;
    string       req;
  } exp_t;

  logic        clk = 0, rstN = 0, byteValid = 0, msTick = 0;
  logic [7:0]  byteData = 0;
  logic [31:0] devAddr = 32'h1234_5678;
  logic [15:0] devType = 16'h0A5C;
  logic [5:0]  fbRdAddr = 0;
  logic [15:0] fbRdData;
  logic        discReq, cmdStrobe, frameReady;
  logic [47:0] replyData;
  logic [7:0]  cmdByte;
  logic [15:0] invalidCount;

  int checks = 0, errors = 0, expInv = 0;
  bit done = 0;
  exp_t expQ[$];

  always #10 clk = ~clk;

  fpkt_receiver u_dut (
    .clk, .rstN, .byteValid, .byteData, .msTick, .devAddr, .devType,
    .fbRdAddr, .fbRdData, .discReq, .replyData, .cmdStrobe, .cmdByte,
    .frameReady, .invalidCount
  );

  task automatic check(input string req, input logic [47:0] act, input logic [47:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: pops scoreboard entries when strobes appear
  task automatic popCmp(input int kind, input logic [47:0] val);
    exp_t e;
    checks++;
    if (expQ.size() == 0) begin
      errors++;
      $display("FAIL unexpected strobe: actual kind=%0d val=%0h expected none", kind, val);
    end else begin
      e = expQ.pop_front();
      if (e.kind != kind || e.val !== val) begin
        errors++;
        $display("FAIL %s: actual kind=%0d val=%0h expected kind=%0d val=%0h",
                 e.req, kind, val, e.kind, e.val);
      end
    end
  endtask

  always @(negedge clk) begin
    if (rstN && !done) begin
      if (discReq)    popCmp(1, replyData);
      if (cmdStrobe)  popCmp(2, {40'h0, cmdByte});
      if (frameReady) popCmp(3, 48'h0);
    end
  end

  task automatic expect_ev(input int kind, input logic [47:0] val, input string req);
    exp_t e;
    e.kind = kind; e.val = val; e.req = req;
    expQ.push_back(e);
  endtask

  task automatic drainCheck(input string req);
    @(negedge clk);
    check(req, 48'(expQ.size()), 48'h0);
    expQ = {};
  endtask

  task automatic sendByte(input logic [7:0] b);
    @(negedge clk);
    byteValid = 1; byteData = b;
    @(negedge clk);
    byteValid = 0; byteData = 0;
  endtask

  task automatic sendPkt(input bq_t pl);
    bq_t enc, blk;
    int code;
    code = 1;
    foreach (pl[i]) begin
      if (pl[i] == 8'h00) begin
        enc.push_back(8'(code));
        foreach (blk[j]) enc.push_back(blk[j]);
        blk = {}; code = 1;
      end else begin
        blk.push_back(pl[i]);
        code++;
        if (code == 255) begin
          enc.push_back(8'hFF);
          foreach (blk[j]) enc.push_back(blk[j]);
          blk = {}; code = 1;
        end
      end
    end
    enc.push_back(8'(code));
    foreach (blk[j]) enc.push_back(blk[j]);
    enc.push_back(8'h00);
    foreach (enc[i]) sendByte(enc[i]);
  endtask

  function automatic logic [7:0] pat(input int half, input int i);
    if (half == 0) return (i % 7 == 0) ? 8'h00 : 8'(i * 3 + 1);
    return (i % 5 == 0) ? 8'h00 : 8'(255 - i);
  endfunction

  function automatic bq_t halfPl(input int half);
    bq_t q;
    for (int i = 0; i < 64; i++) q.push_back(pat(half, i));
    return q;
  endfunction

  function automatic logic [15:0] expWord(input int half, input int k);
    return {pat(half, 2 * k + 1), pat(half, 2 * k)};
  endfunction

  task automatic readWord(input string req, input int half, input int k, input logic [15:0] exp);
    fbRdAddr = 6'(half * 32 + k);
    #1;
    check(req, 48'(fbRdData), 48'(exp));
  endtask

  task automatic sendAddr(input logic [31:0] a);
    sendPkt('{a[7:0], a[15:8], a[23:16], a[31:24]});
  endtask

  task automatic checkInv(input string req);
    check(req, 48'(invalidCount), 48'(expInv));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    bq_t big;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R11 reset state
    check("R11 invalidCount", 48'(invalidCount), 48'h0);
    check("R11 strobes", 48'({discReq, cmdStrobe, frameReady}), 48'h0);
    readWord("R11 fb word 0", 0, 0, 16'h0);
    readWord("R11 fb word 63", 1, 31, 16'h0);

    // R1: pre-sync bytes, then sync, then empty packet
    sendByte(8'h03); sendByte(8'h11); sendByte(8'h22);
    sendByte(8'h00); sendByte(8'h00);
    drainCheck("R1 no strobe");
    checkInv("R1 no invalid before sync / on empty packet");

    // R9: code byte then delimiter = zero-length packet
    sendByte(8'h01); sendByte(8'h00);
    expInv++;
    checkInv("R9 zero-length packet");

    // R3 discovery inside boot window
    expect_ev(1, {devType, devAddr}, "R3 discovery reply");
    sendPkt('{8'h00});
    drainCheck("R3 discovery seen");

    // R5 command
    expect_ev(2, 48'h5A, "R5 command byte");
    sendPkt('{8'h5A});
    drainCheck("R5 command seen");

    // R6 mismatch then data -> invalid
    sendAddr(devAddr ^ 32'h0100_0000);
    sendPkt(halfPl(0));
    expInv++;
    checkInv("R6 mismatch leaves ignore state");

    // R7/R8 full frame with stuffed zeros (R2)
    sendAddr(devAddr);
    sendPkt(halfPl(0));
    drainCheck("R7 no frameReady after first half");
    expect_ev(3, 48'h0, "R8 frameReady");
    sendPkt(halfPl(1));
    drainCheck("R8 frameReady seen");
    checkInv("R7 no invalid on good frame");
    readWord("R12 half0 word0", 0, 0, expWord(0, 0));
    readWord("R2 half0 word5", 0, 5, expWord(0, 5));
    readWord("R12 half0 word31", 0, 31, expWord(0, 31));
    readWord("R2 half1 word0", 1, 0, expWord(1, 0));
    readWord("R12 half1 word17", 1, 17, expWord(1, 17));

    // R8 state back to ignore after frame
    sendPkt(halfPl(1));
    expInv++;
    checkInv("R8 ignore after frame");

    // R5 command drops addressed state
    sendAddr(devAddr);
    expect_ev(2, 48'h33, "R5 command in addressed state");
    sendPkt('{8'h33});
    sendPkt(halfPl(1));
    expInv++;
    drainCheck("R5 command seen");
    checkInv("R5 command returns to ignore");
    readWord("R5 half0 untouched", 0, 3, expWord(0, 3));

    // R9 odd length
    sendPkt('{8'h01, 8'h02, 8'h03, 8'h04, 8'h05});
    expInv++;
    checkInv("R9 length 5");

    // R10 overflow
    sendAddr(devAddr);
    for (int i = 0; i < 70; i++) big.push_back(8'h11);
    sendPkt(big);
    expInv++;
    checkInv("R10 overflow counted");
    readWord("R10 half0 word0 unchanged", 0, 0, expWord(0, 0));
    readWord("R10 half0 word31 unchanged", 0, 31, expWord(0, 31));
    sendPkt(halfPl(1));
    expInv++;
    checkInv("R10 ignore after overflow");

    // R4 discovery after the boot window
    for (int i = 0; i < 100; i++) begin
      @(negedge clk); msTick = 1;
      @(negedge clk); msTick = 0;
    end
    sendPkt('{8'h00});
    drainCheck("R4 no reply after window");
    checkInv("R4 discovery not invalid");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule